// File: doc/BRIEF.md
# GCD Accelerator with Register Interface

This peripheral computes the greatest common divisor of two unsigned operands of configurable width. Software reaches it through a small register window of 4 KiB placed at a configurable base address. The port has an address, a write strobe with write data, and a read strobe with read data that is returned combinationally in the same cycle.

Software polls a status word until the engine can take new operands, then writes the first operand and then the second. The second write also launches the computation. Software then polls until a result is waiting and reads it, and that read frees the engine for the next pair.

Inside, an engine that subtracts repeatedly sits behind a ready/valid handshake on both its input and its output. Its busy flag is driven onto a top-level pin.

Top module: `gcd_mmio_periph`

## Requirements
- R1: After reset the status word reads 2'b10 (ready, no result), the busy pin is low, and the result register reads zero.
- R2: The status register at offset 0x00 holds input-ready in bit 1 and result-waiting in bit 0. All of its higher bits read zero.
- R3: A write to offset 0x04 stores the first operand and starts nothing. Busy stays low and status stays 2'b10.
- R4: A write to offset 0x08 while the engine is ready launches a computation. From the next cycle, busy is high and status bit 1 is low.
- R5: The result register at offset 0x0C returns the GCD of the two stored operands once status bit 0 is set. For example, 20 and 15 give 5.
- R6: If one operand is zero, the result is the other operand. If both are zero, the result is zero and it still completes.
- R7: A read of offset 0x0C while a result is waiting consumes that result. From the next cycle, status reads 2'b10 and busy is low. Until that read, the result and status bit 0 hold steady.
- R8: Reads of offsets 0x04 and 0x08, of any other unmapped offset, and of any address outside the window all return zero.
- R9: Writes to offsets 0x00 and 0x0C and to unmapped offsets have no effect. They launch nothing and do not change a pending result.
- R10: Accesses to addresses outside the window at the base address are ignored, even when their low bits match a register offset.
- R11: A write to offset 0x08 while the engine is busy is ignored. The pending computation finishes with its original operands.
- R12: Busy stays high, and status bit 1 stays low, from the accepted launch until the result is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe; a result read pops on the clock edge |
| rd_data | output | DW | Read data, valid in the same cycle as rd_en |
| busy | output | 1 | Engine holds an operand pair or an unread result |

## Verification
The assertions check the handshake rules on every cycle. An accepted launch must raise busy. A waiting result must hold steady until it is popped, and a pop must return the engine to ready. Out-of-window reads must return zero, and writes to the first operand or out-of-window writes must not launch anything. Only the bench scenarios can show that results are arithmetically correct, including the zero-operand cases. The same holds for a stored first operand being reused by a later launch and for a second-operand write during a busy interval being dropped.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int WIN_BITS = 12;  // 4 KiB register window

  localparam logic [WIN_BITS-1:0] OFS_STATUS = 12'h000;
  localparam logic [WIN_BITS-1:0] OFS_XOP    = 12'h004;
  localparam logic [WIN_BITS-1:0] OFS_YOP    = 12'h008;
  localparam logic [WIN_BITS-1:0] OFS_RESULT = 12'h00C;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/gcd_engine.sv
module gcd_engine #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             busy
);
  import gcd_pkg::*;

  eng_state_e       state_q, state_d;
  logic [WIDTH-1:0] a_q, a_d, b_q, b_d, res_q, res_d;

  always_comb begin
    state_d = state_q;
    a_d     = a_q;
    b_d     = b_q;
    res_d   = res_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (in_valid) begin
          a_d     = x;
          b_d     = y;
          state_d = ENG_RUN;
        end
      end
      ENG_RUN: begin
        if (a_q == '0 || b_q == '0) begin
          res_d   = a_q | b_q;   // one side is zero: the other is the answer
          state_d = ENG_DONE;
        end else if (a_q >= b_q) begin
          a_d = a_q - b_q;
        end else begin
          b_d = b_q - a_q;
        end
      end
      ENG_DONE: begin
        if (out_ready) state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      a_q     <= a_d;
      b_q     <= b_d;
      res_q   <= res_d;
    end
  end

  assign in_ready  = (state_q == ENG_IDLE);
  assign out_valid = (state_q == ENG_DONE);
  assign busy      = (state_q != ENG_IDLE);
  assign result    = res_q;
endmodule

// File: rtl/gcd_regs.sv
module gcd_regs #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          WIDTH     = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic             eng_in_ready,
  input  logic             eng_out_valid,
  input  logic [WIDTH-1:0] eng_result,
  output logic             eng_in_valid,
  output logic             eng_out_ready,
  output logic [WIDTH-1:0] x_op,
  output logic [WIDTH-1:0] y_op
);
  import gcd_pkg::*;

  localparam logic [AW-1:0] BASE_V = AW'(BASE_ADDR);

  logic                win_hit;
  logic [WIN_BITS-1:0] ofs;
  logic                wr_x, wr_y, rd_res;
  logic [WIDTH-1:0]    x_q, x_d;

  assign win_hit = (addr[AW-1:WIN_BITS] == BASE_V[AW-1:WIN_BITS]);
  assign ofs     = addr[WIN_BITS-1:0];

  assign wr_x   = wr_en && win_hit && (ofs == OFS_XOP);
  assign wr_y   = wr_en && win_hit && (ofs == OFS_YOP);
  assign rd_res = rd_en && win_hit && (ofs == OFS_RESULT);

  always_comb begin
    x_d = x_q;
    if (wr_x) x_d = wr_data[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= x_d;
  end

  assign x_op          = x_q;
  assign y_op          = wr_data[WIDTH-1:0];
  assign eng_in_valid  = wr_y;
  assign eng_out_ready = rd_res;

  always_comb begin
    rd_data = '0;
    if (rd_en && win_hit) begin
      if (ofs == OFS_STATUS) rd_data[1:0] = {eng_in_ready, eng_out_valid};
      else if (ofs == OFS_RESULT) rd_data[WIDTH-1:0] = eng_result;
    end
  end
endmodule

// File: rtl/gcd_mmio_periph.sv
module gcd_mmio_periph #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          WIDTH     = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic             eng_in_valid, eng_in_ready;
  logic             eng_out_valid, eng_out_ready;
  logic [WIDTH-1:0] x_op, y_op, eng_result;

  gcd_regs #(
    .AW(AW), .DW(DW), .WIDTH(WIDTH), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .eng_in_ready  (eng_in_ready),
    .eng_out_valid (eng_out_valid),
    .eng_result    (eng_result),
    .eng_in_valid  (eng_in_valid),
    .eng_out_ready (eng_out_ready),
    .x_op          (x_op),
    .y_op          (y_op)
  );

  gcd_engine #(.WIDTH(WIDTH)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (eng_in_valid),
    .in_ready  (eng_in_ready),
    .x         (x_op),
    .y         (y_op),
    .out_ready (eng_out_ready),
    .out_valid (eng_out_valid),
    .result    (eng_result),
    .busy      (busy)
  );
endmodule

// File: rtl/gcd_mmio_checker.sv
module gcd_mmio_checker #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          WIDTH     = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    rd_data,
  input logic             busy,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] result
);
  localparam logic [AW-1:0] BASE_V = AW'(BASE_ADDR);

  logic in_win, wr_x_hit;
  assign in_win   = (addr[AW-1:gcd_pkg::WIN_BITS] == BASE_V[AW-1:gcd_pkg::WIN_BITS]);
  assign wr_x_hit = wr_en && in_win && (addr[gcd_pkg::WIN_BITS-1:0] == gcd_pkg::OFS_XOP);

  assert_launch_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !in_ready);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result));

  assert_pop_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && !busy && in_ready);

  assert_busy_blocks_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(out_valid && out_ready) |=> busy && !in_ready);

  assert_outside_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !in_win |-> rd_data == '0);

  assert_first_op_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_x_hit && !busy |=> !busy);

  assert_outside_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !in_win && !busy |=> !busy);
endmodule

bind gcd_mmio_periph gcd_mmio_checker #(
  .AW(AW), .DW(DW), .WIDTH(WIDTH), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .busy      (busy),
  .in_valid  (eng_in_valid),
  .in_ready  (eng_in_ready),
  .out_valid (eng_out_valid),
  .out_ready (eng_out_ready),
  .result    (eng_result)
);

// File: tb/sim_gcd_mmio_periph.sv
module sim_gcd_mmio_periph;
  localparam int          AW    = 32;
  localparam int          DW    = 32;
  localparam logic [31:0] BASE  = 32'h0001_0000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          busy;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #4 clk = ~clk;  // 125 MHz

  gcd_mmio_periph #(.AW(AW), .DW(DW), .WIDTH(32), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  function automatic logic [31:0] ref_gcd(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] t;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drives at the falling edge; the access lands on the next rising edge.
  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_status(input int bitpos, input string req);
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(BASE + 32'h0, s);
      if (s[bitpos]) return;
    end
    check(req, 32'h0, 32'h1);
  endtask

  task automatic run_pair(input logic [31:0] x, input logic [31:0] y, input string req);
    logic [31:0] d;
    wait_status(1, req);
    bus_write(BASE + 32'h4, x);
    check("R3 busy after first operand", {31'b0, busy}, 32'h0);
    bus_write(BASE + 32'h8, y);
    check("R4 busy after launch", {31'b0, busy}, 32'h1);
    bus_read(BASE + 32'h0, d);
    check("R12 ready low while busy", {31'b0, d[1]}, 32'h0);
    wait_status(0, req);
    bus_read(BASE + 32'hC, d);
    check(req, d, ref_gcd(x, y));
    bus_read(BASE + 32'h0, d);
    check("R7 status after pop", d, 32'h2);
    check("R7 busy after pop", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(BASE + 32'h0, d);
    check("R1 status at reset", d, 32'h2);
    check("R1 busy at reset", {31'b0, busy}, 32'h0);
    bus_read(BASE + 32'hC, d);
    check("R1 result at reset", d, 32'h0);
  endtask

  task automatic t_main;
    run_pair(32'd20, 32'd15, "R5 gcd 20,15");
    run_pair(32'd48, 32'd18, "R5 gcd 48,18");
    run_pair(32'd7, 32'd13, "R5 gcd 7,13");
    run_pair(32'd100, 32'd100, "R5 gcd 100,100");
    run_pair(32'd1071, 32'd462, "R5 gcd 1071,462");
  endtask

  task automatic t_zero;
    run_pair(32'd0, 32'd9, "R6 zero first");
    run_pair(32'd9, 32'd0, "R6 zero second");
    run_pair(32'd0, 32'd0, "R6 both zero");
  endtask

  task automatic t_status_and_reads;
    logic [31:0] d;
    bus_write(BASE + 32'h4, 32'd77);
    bus_read(BASE + 32'h0, d);
    check("R2 status idle, upper bits zero", d, 32'h2);
    bus_read(BASE + 32'h4, d);
    check("R8 read of first operand", d, 32'h0);
    bus_read(BASE + 32'h8, d);
    check("R8 read of second operand", d, 32'h0);
    bus_read(BASE + 32'h10, d);
    check("R8 read unmapped 0x10", d, 32'h0);
    bus_read(BASE + 32'hFFC, d);
    check("R8 read unmapped 0xFFC", d, 32'h0);
  endtask

  task automatic t_first_op_stored;
    logic [31:0] d;
    bus_write(BASE + 32'h4, 32'd36);
    repeat (3) @(negedge clk);
    check("R3 no start", {31'b0, busy}, 32'h0);
    bus_read(BASE + 32'h0, d);
    check("R3 status unchanged", d, 32'h2);
    bus_write(BASE + 32'h8, 32'd24);
    wait_status(0, "R3 stored operand used");
    bus_read(BASE + 32'hC, d);
    check("R3 stored operand used", d, 32'd12);
  endtask

  task automatic t_ignored_writes;
    logic [31:0] d;
    bus_write(BASE + 32'h0, 32'hFFFF_FFFF);
    bus_write(BASE + 32'hC, 32'hFFFF_FFFF);
    bus_write(BASE + 32'h20, 32'hFFFF_FFFF);
    check("R9 no launch from ignored writes", {31'b0, busy}, 32'h0);
    bus_read(BASE + 32'h0, d);
    check("R9 status after ignored writes", d, 32'h2);
    bus_write(BASE + 32'h4, 32'd21);
    bus_write(BASE + 32'h8, 32'd14);
    wait_status(0, "R9 pending result");
    bus_write(BASE + 32'hC, 32'd999);
    bus_write(BASE + 32'h0, 32'd0);
    bus_read(BASE + 32'h0, d);
    check("R9 result still waiting", d, 32'h1);
    bus_read(BASE + 32'hC, d);
    check("R9 pending result unchanged", d, 32'd7);
  endtask

  task automatic t_window;
    logic [31:0] d;
    bus_write(BASE + 32'h1000 + 32'h8, 32'd5);
    bus_write(BASE - 32'h1000 + 32'h8, 32'd5);
    check("R10 no launch outside window", {31'b0, busy}, 32'h0);
    bus_read(BASE + 32'h1000, d);
    check("R10 read outside window", d, 32'h0);
    bus_write(BASE + 32'h1004, 32'd50);
    bus_write(BASE + 32'h4, 32'd30);
    bus_write(BASE + 32'h8, 32'd45);
    wait_status(0, "R10 operand kept");
    bus_read(BASE + 32'hC, d);
    check("R10 outside write did not touch operand", d, 32'd15);
  endtask

  task automatic t_busy_write;
    logic [31:0] d;
    bus_write(BASE + 32'h4, 32'd20);
    bus_write(BASE + 32'h8, 32'd15);
    bus_write(BASE + 32'h8, 32'd7);
    wait_status(0, "R11 result");
    bus_write(BASE + 32'h8, 32'd3);
    bus_read(BASE + 32'hC, d);
    check("R11 busy write ignored", d, 32'd5);
    check("R12 busy low after pop", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_main();
    t_zero();
    t_status_and_reads();
    t_first_op_stored();
    t_ignored_writes();
    t_window();
    t_busy_write();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule